// File: doc/BRIEF.md
# Indexed NVRAM Byte Port with Lockable Windows

This block puts a byte-wide nonvolatile RAM behind a four-offset I/O window. Software first loads a 16-bit pointer one byte at a time through two pointer offsets, then moves one data byte through the data offset. After every data-offset write the pointer returns to zero by itself. Because of this, each store needs a fresh pointer load. Reads through the data offset do not move the pointer.

Two lock bits guard two fixed 16-byte windows of the RAM. While its bit is set, a window drops writes and reads back as all ones. Each lock bit flips when a one-cycle toggle strobe arrives with a select input that names the bit. Pointers at or above the configured RAM depth reach no storage. Reset clears the pointer, the lock bits and the read-data register. It leaves the RAM contents alone, because the storage is meant to keep its data.

The requester asserts `pio_wr` or `pio_rd` for one cycle with an offset. It never asserts both in the same cycle. Read data is registered. It appears on `pio_rdata` in the cycle after the read strobe and stays there until the next read.

Top module: `nvram_port_window`

## Requirements
- R1: A write to offset 0 replaces bits 7:0 of the pointer and a write to offset 1 replaces bits 15:8; the other byte keeps its value.
- R2: A write to offset 3 stores the byte at the RAM cell the pointer names, and the pointer is zero afterwards. Reads at any offset leave the pointer unchanged.
- R3: A read at offset 3 returns the byte at the pointer on `pio_rdata` one cycle after the strobe. A read at offsets 0, 1 or 2 returns 0xFF. Without a read strobe, `pio_rdata` holds its value.
- R4: A write to offset 2 changes neither the pointer nor the RAM.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F are protected. While lock bit 1 is set, addresses 0x30 to 0x3F are protected. A write to a protected address stores nothing and a read from one returns 0xFF. Addresses 0x1F and 0x40 are never protected.
- R6: A cycle with `lock_flip` high inverts the lock bit named by `lock_sel` and leaves the other lock bit unchanged. A second toggle of the same bit removes the protection again.
- R7: A pointer at or above DEPTH (default 512) stores nothing on a data write and reads 0xFF. Such writes do not wrap onto lower cells.
- R8: Reset makes the pointer zero, clears both lock bits and sets `pio_rdata` to 0xFF.
- R9: RAM contents written before a reset are read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_wr | input | 1 | One-cycle write strobe |
| pio_rd | input | 1 | One-cycle read strobe |
| pio_off | input | 2 | Offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| pio_wdata | input | 8 | Write byte |
| pio_rdata | output | 8 | Registered read byte |
| lock_flip | input | 1 | Toggle strobe for one lock bit |
| lock_sel | input | 1 | Lock bit selected by the toggle (0 or 1) |

## Verification
On every cycle, the embedded properties check several rules. Pointer-byte loads land in the right half. A data write zeroes the pointer and a spare-offset write leaves it alone. A toggle flips exactly the selected lock bit. Reads at non-data offsets, at protected addresses or beyond the depth return 0xFF, and read data holds between strobes.

Some behaviour involves RAM contents or spans a reset, and only the bench's scenarios can show it. This covers dropped protected writes that read back the old byte once the window is unlocked, the absence of wrap-around beyond the depth, retention across reset, and stores that land at address zero after the pointer has cleared itself.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

   localparam int BYTE_W = 8;
   localparam int PTR_W  = 2 * BYTE_W;

   typedef enum logic [1:0] {
      OFF_PTR_LO = 2'd0,
      OFF_PTR_HI = 2'd1,
      OFF_SPARE  = 2'd2,
      OFF_DATA   = 2'd3
   } nvp_off_e;

   localparam logic [BYTE_W-1:0] BLANK_BYTE = '1;

endpackage

// File: rtl/nvp_ptr_reg.sv
module nvp_ptr_reg import nvp_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              clr,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [PTR_W-1:0]  ptr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else begin
         if (ld_lo) ptr[BYTE_W-1:0]     <= byte_in;
         if (ld_hi) ptr[PTR_W-1:BYTE_W] <= byte_in;
      end
   end

   AST_PTR_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo && !ld_hi && !clr |=> ptr[BYTE_W-1:0] == $past(byte_in) &&
                                  ptr[PTR_W-1:BYTE_W] == $past(ptr[PTR_W-1:BYTE_W])); // R1
   AST_PTR_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi && !ld_lo && !clr |=> ptr[PTR_W-1:BYTE_W] == $past(byte_in) &&
                                  ptr[BYTE_W-1:0] == $past(ptr[BYTE_W-1:0])); // R1
   AST_PTR_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ptr == '0); // R2

endmodule

// File: rtl/nvp_lock_ctrl.sv
module nvp_lock_ctrl import nvp_pkg::*; #(
   parameter int NUM_LOCKS = 2,
   parameter int WIN_BASE  = 32,
   parameter int WIN_SPAN  = 16,
   parameter int SEL_W     = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] ptr,
   input  logic             flip,
   input  logic [SEL_W-1:0] sel,
   output logic             prot
);

   logic [NUM_LOCKS-1:0] lock_q;
   logic [NUM_LOCKS-1:0] win_hit;

   for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_win
      localparam logic [PTR_W:0] LO = (PTR_W+1)'(WIN_BASE + k * WIN_SPAN);
      localparam logic [PTR_W:0] HI = (PTR_W+1)'(WIN_BASE + (k + 1) * WIN_SPAN);

      assign win_hit[k] = ({1'b0, ptr} >= LO) && ({1'b0, ptr} < HI);

      always_ff @(posedge clk) begin
         if (!rst_n)
            lock_q[k] <= 1'b0;
         else if (flip && sel == SEL_W'(k))
            lock_q[k] <= ~lock_q[k];
      end
   end

   assign prot = |(win_hit & lock_q);

   AST_LOCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> lock_q == ($past(lock_q) ^ (NUM_LOCKS'(1) << $past(sel)))); // R6
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> $stable(lock_q)); // R6
   AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_hit)); // R5

endmodule

// File: rtl/nvp_byte_store.sv
module nvp_byte_store import nvp_pkg::*; #(
   parameter int DEPTH = 512,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wbyte,
   output logic [BYTE_W-1:0] rbyte
);

   logic [BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[idx] <= wbyte;
   end

   assign rbyte = cells[idx];

endmodule

// File: rtl/nvram_port_window.sv
module nvram_port_window import nvp_pkg::*; #(
   parameter int DEPTH     = 512,
   parameter int NUM_LOCKS = 2,
   parameter int WIN_BASE  = 32,
   parameter int WIN_SPAN  = 16,
   localparam int SEL_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pio_wr,
   input  logic              pio_rd,
   input  logic [1:0]        pio_off,
   input  logic [BYTE_W-1:0] pio_wdata,
   output logic [BYTE_W-1:0] pio_rdata,
   input  logic              lock_flip,
   input  logic [SEL_W-1:0]  lock_sel
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || DEPTH > (1 << PTR_W)) begin : g_bad_depth
      $error("DEPTH must lie in 2..65536");
   end
   if (NUM_LOCKS < 1 || WIN_SPAN < 1 ||
       WIN_BASE + NUM_LOCKS * WIN_SPAN > (1 << PTR_W)) begin : g_bad_win
      $error("lock windows must fit the pointer range");
   end

   logic [PTR_W-1:0]  ptr;
   logic              prot;
   logic              in_range;
   logic              cell_ok;
   logic              hit_data;
   logic              ram_we;
   logic [BYTE_W-1:0] ram_q;

   assign hit_data = (pio_off == OFF_DATA);
   assign in_range = ({1'b0, ptr} < (PTR_W+1)'(DEPTH));
   assign cell_ok  = in_range && !prot;
   assign ram_we   = pio_wr && hit_data && cell_ok;

   nvp_ptr_reg u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (pio_wr && pio_off == OFF_PTR_LO),
      .ld_hi   (pio_wr && pio_off == OFF_PTR_HI),
      .clr     (pio_wr && hit_data),
      .byte_in (pio_wdata),
      .ptr     (ptr)
   );

   nvp_lock_ctrl #(
      .NUM_LOCKS (NUM_LOCKS),
      .WIN_BASE  (WIN_BASE),
      .WIN_SPAN  (WIN_SPAN),
      .SEL_W     (SEL_W)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .ptr   (ptr),
      .flip  (lock_flip),
      .sel   (lock_sel),
      .prot  (prot)
   );

   nvp_byte_store #(.DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (ram_we),
      .idx   (ptr[IDX_W-1:0]),
      .wbyte (pio_wdata),
      .rbyte (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         pio_rdata <= BLANK_BYTE;
      else if (pio_rd)
         pio_rdata <= (hit_data && cell_ok) ? ram_q : BLANK_BYTE;
   end

   AST_RD_OTHER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      pio_rd && pio_off != OFF_DATA |=> pio_rdata == BLANK_BYTE); // R3
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pio_rd |=> $stable(pio_rdata)); // R3
   AST_PROT_RD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      pio_rd && prot |=> pio_rdata == BLANK_BYTE); // R5
   AST_FAR_RD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      pio_rd && !in_range |=> pio_rdata == BLANK_BYTE); // R7
   AST_SPARE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pio_wr && pio_off == OFF_SPARE |=> $stable(ptr)); // R4
   AST_RD_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pio_rd && !pio_wr |=> $stable(ptr)); // R2

endmodule

// File: tb/tb_nvram_port_window.sv
module tb_nvram_port_window;

   localparam int DEPTH = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pio_wr = 1'b0;
   logic       pio_rd = 1'b0;
   logic [1:0] pio_off = 2'd0;
   logic [7:0] pio_wdata = 8'h00;
   logic [7:0] pio_rdata;
   logic       lock_flip = 1'b0;
   logic [0:0] lock_sel = 1'b0;

   always #4 clk = ~clk;

   nvram_port_window #(.DEPTH(DEPTH)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pio_wr    (pio_wr),
      .pio_rd    (pio_rd),
      .pio_off   (pio_off),
      .pio_wdata (pio_wdata),
      .pio_rdata (pio_rdata),
      .lock_flip (lock_flip),
      .lock_sel  (lock_sel)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int         m_ptr;
   logic [1:0] m_lock;
   int         m_mem [DEPTH];
   bit         m_known [DEPTH];
   int         m_rdata;
   bit         m_rknown;

   function automatic bit m_prot(input int a);
      return (a >= 32 && a < 48 && m_lock[0]) || (a >= 48 && a < 64 && m_lock[1]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ptr = 0; m_lock = 2'b00; m_rdata = 255; m_rknown = 1;
      end else begin
         if (pio_rd) begin
            if (pio_off == 2'd3 && m_ptr < DEPTH && !m_prot(m_ptr)) begin
               m_rdata = m_mem[m_ptr]; m_rknown = m_known[m_ptr];
            end else begin
               m_rdata = 255; m_rknown = 1;
            end
         end
         if (pio_wr) begin
            case (pio_off)
               2'd0: m_ptr = (m_ptr & 'hFF00) | int'(pio_wdata);
               2'd1: m_ptr = (m_ptr & 'h00FF) | (int'(pio_wdata) << 8);
               2'd3: begin
                  if (m_ptr < DEPTH && !m_prot(m_ptr)) begin
                     m_mem[m_ptr] = int'(pio_wdata); m_known[m_ptr] = 1;
                  end
                  m_ptr = 0;
               end
               default: ;
            endcase
         end
         if (lock_flip) m_lock[lock_sel] = ~m_lock[lock_sel];
      end
   end

   // per-cycle comparison against the model (R3)
   always @(negedge clk) begin
      if (rst_n && m_rknown && !done)
         chk(int'(pio_rdata) == m_rdata, "R3 per-cycle rdata", int'(pio_rdata), m_rdata);
   end

   task automatic bus_wr(input logic [1:0] o, input logic [7:0] d);
      @(negedge clk); pio_wr = 1'b1; pio_off = o; pio_wdata = d;
      @(negedge clk); pio_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] o, output logic [7:0] v);
      @(negedge clk); pio_rd = 1'b1; pio_off = o;
      @(negedge clk); pio_rd = 1'b0; v = pio_rdata;
   endtask

   task automatic set_ptr(input logic [15:0] a);
      bus_wr(2'd0, a[7:0]);
      bus_wr(2'd1, a[15:8]);
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      set_ptr(a);
      bus_wr(2'd3, d);
   endtask

   task automatic peek(input logic [15:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v;
      set_ptr(a);
      bus_rd(2'd3, v);
      chk(v == exp, tag, int'(v), int'(exp));
   endtask

   task automatic toggle(input logic s);
      @(negedge clk); lock_flip = 1'b1; lock_sel = s;
      @(negedge clk); lock_flip = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual=00 expected=01");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk(pio_rdata == 8'hFF, "R8 rdata during reset", int'(pio_rdata), 'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pio_rdata == 8'hFF, "R8 rdata after reset", int'(pio_rdata), 'hFF);

      // R1/R2: basic store and fetch
      poke(16'h0105, 8'h5A);
      peek(16'h0105, 8'h5A, "R1 two-byte pointer store/fetch");
      set_ptr(16'h0140);
      bus_wr(2'd0, 8'h05);
      bus_rd(2'd3, v);
      chk(v == 8'h5A, "R1 low load keeps high byte", int'(v), 'h5A);

      // R2: pointer self-clears after a data write
      poke(16'h0077, 8'h33);
      bus_wr(2'd3, 8'hC4);
      peek(16'h0000, 8'hC4, "R2 second store lands at zero");
      peek(16'h0077, 8'h33, "R2 first store intact");

      // R3: other offsets read blank, reads do not move the pointer
      set_ptr(16'h0105);
      bus_rd(2'd0, v); chk(v == 8'hFF, "R3 offset0 read", int'(v), 'hFF);
      bus_rd(2'd1, v); chk(v == 8'hFF, "R3 offset1 read", int'(v), 'hFF);
      bus_rd(2'd2, v); chk(v == 8'hFF, "R3 offset2 read", int'(v), 'hFF);
      bus_rd(2'd3, v); chk(v == 8'h5A, "R2 pointer kept across reads", int'(v), 'h5A);
      repeat (3) @(negedge clk);
      chk(pio_rdata == 8'h5A, "R3 rdata holds", int'(pio_rdata), 'h5A);

      // R4: spare offset write has no effect
      set_ptr(16'h0040);
      bus_wr(2'd2, 8'h99);
      bus_wr(2'd3, 8'h21);
      peek(16'h0040, 8'h21, "R4 spare write ignored");
      peek(16'h0000, 8'hC4, "R4 no store via spare");

      // R5/R6: lock windows
      poke(16'h0025, 8'hAB);
      poke(16'h0035, 8'hCD);
      poke(16'h001F, 8'h1F);
      poke(16'h002F, 8'h2F);
      poke(16'h0030, 8'h30);
      toggle(1'b0);
      peek(16'h0025, 8'hFF, "R5 lock0 read blank");
      peek(16'h002F, 8'hFF, "R5 lock0 top edge blank");
      peek(16'h0035, 8'hCD, "R6 lock1 untouched by lock0 toggle");
      peek(16'h001F, 8'h1F, "R5 0x1F never protected");
      poke(16'h0025, 8'h00);
      toggle(1'b1);
      peek(16'h0030, 8'hFF, "R5 lock1 bottom edge blank");
      poke(16'h0035, 8'h00);
      poke(16'h0040, 8'h44);
      peek(16'h0040, 8'h44, "R5 0x40 never protected");
      toggle(1'b0);
      peek(16'h0025, 8'hAB, "R6 unlock0 shows old byte, write dropped");
      peek(16'h0035, 8'hFF, "R6 lock1 still set");
      toggle(1'b1);
      peek(16'h0035, 8'hCD, "R5 protected write dropped");

      // R7: beyond depth
      poke(16'h01FF, 8'h5E);
      poke(16'h03FF, 8'h11);
      poke(16'h0200, 8'h22);
      poke(16'hFFFF, 8'h33);
      peek(16'h0200, 8'hFF, "R7 depth boundary blank");
      peek(16'hFFFF, 8'hFF, "R7 top pointer blank");
      peek(16'h01FF, 8'h5E, "R7 no wrap onto last cell");
      peek(16'h0000, 8'hC4, "R7 no wrap onto cell zero");

      // R8/R9: reset mid-operation
      toggle(1'b0);
      set_ptr(16'h0105);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk(pio_rdata == 8'hFF, "R8 rdata after mid reset", int'(pio_rdata), 'hFF);
      bus_rd(2'd3, v);
      chk(v == 8'hC4, "R8 pointer cleared by reset", int'(v), 'hC4);
      peek(16'h0025, 8'hAB, "R8 locks cleared by reset");
      peek(16'h0105, 8'h5A, "R9 contents survive reset");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule